// File: doc/BRIEF.md
# Exception Priority Masking Unit

This unit decides, cycle by cycle, whether the exception that the interrupt controller currently presents may preempt the running code. It keeps three software-visible mask registers: a one-bit switch that shuts out every configurable exception, a one-bit switch that also shuts out the hard fault, and a programmable priority threshold. Each active mask pulls the execution priority down to its own floor. The pending exception is taken only when its priority is strictly more urgent than the result. Priorities are signed, and a smaller value is more urgent.

Software reads and writes the masks through a small strobe interface. Only privileged code can reach them. An exception-return pulse from the core drops the fault mask automatically. A typical use is a nestable critical section: read the old threshold, write a stricter one, then restore the saved value on the way out.

Top module: `exc_mask_unit`

## Requirements
- R1: After reset all three masks are zero, every register reads back zero, and a configurable exception more urgent than `curPrio` is taken.
- R2: An exception is taken only if its priority is strictly less than `boostPrio`. An equal value is not taken.
- R3: `boostPrio` is the minimum of `curPrio`, 0 when the global mask is set, -1 when the fault mask is set, and the threshold when it is nonzero. All priorities are two's complement, `PRIO_BITS+2` bits wide.
- R4: With the global mask set, no configurable exception is taken, while the hard fault and NMI are still taken when `curPrio` allows.
- R5: With the fault mask set, the hard fault is also blocked, and only NMI can preempt.
- R6: An `excReturn` pulse clears the fault mask at the next edge, and it wins over a same-cycle write to that mask. The global mask and the threshold keep their values.
- R7: A nonzero threshold T blocks configurable exceptions with priority of T or above, and lets more urgent ones through. A threshold of zero masks nothing.
- R8: When `privileged` is low, register writes are ignored and `regRdData` is zero.
- R9: A register write changes the masking decision and the read data from the cycle after the write edge, not in the cycle of the write.
- R10: `pendClass` 00 is configurable and uses `pendPrio`. 01 is the hard fault at -1. 10 is NMI at -2, which no mask blocks. 11 is never taken. With `pendValid` low nothing is taken. `takeNum` equals `pendNum` when taken and is zero otherwise.
- R11: `regSel` 0 selects the global mask (data bit 0), 1 the fault mask (bit 0), 2 the threshold (bits PRIO_BITS-1:0), and 3 reads zero and writes nothing. Read data is combinational while `regRdEn` is high and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pendValid | input | 1 | A pending exception is presented |
| pendNum | input | NUM_BITS | Number of the pending exception |
| pendPrio | input | PRIO_BITS | Priority of a configurable pending exception |
| pendClass | input | 2 | Class: 00 configurable, 01 hard fault, 10 NMI, 11 reserved |
| curPrio | input | PRIO_BITS+2 | Signed current execution priority (2^PRIO_BITS in thread mode) |
| privileged | input | 1 | Register access is allowed |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regSel | input | 2 | Register select |
| regWrData | input | DATA_W | Write data |
| excReturn | input | 1 | Exception-return pulse |
| takeExc | output | 1 | Pending exception may preempt |
| takeNum | output | NUM_BITS | Number of the exception taken, zero otherwise |
| boostPrio | output | PRIO_BITS+2 | Signed effective boosted priority |
| regRdData | output | DATA_W | Register read data |

## Verification
A wrong mask bit or threshold shows on `boostPrio` in the first cycle after the faulty edge, even when nothing is pending. It shows on `takeExc` as soon as an exception lands between the correct and the wrong floor. Because the bench checks `boostPrio`, `takeExc`, `takeNum` and the read data in every cycle, a lost fault-mask clear or a leaked unprivileged write surfaces one cycle after it occurs. The nested save and restore of the threshold confirms that masking comes back to exactly the prior state.

// File: rtl/exc_mask_pkg.sv
package exc_mask_pkg;

  typedef enum logic [1:0] {
    CLS_CFG  = 2'b00,
    CLS_HARD = 2'b01,
    CLS_NMI  = 2'b10,
    CLS_RSVD = 2'b11
  } excClass_e;

  typedef enum logic [1:0] {
    SEL_GLOBAL = 2'd0,
    SEL_FAULT  = 2'd1,
    SEL_THRESH = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrGlobal;
    logic wrFault;
    logic wrThresh;
    logic clrFault;
    logic rdGlobal;
    logic rdFault;
    logic rdThresh;
  } maskStrb_t;

endpackage

// File: rtl/exc_mask_ctrl.sv
module exc_mask_ctrl
  import exc_mask_pkg::*;
(
  input  logic      privileged,
  input  logic      regWrEn,
  input  logic      regRdEn,
  input  regSel_e   regSel,
  input  logic      excReturn,
  output maskStrb_t strb
);

  logic wrOk;
  logic rdOk;

  always_comb begin
    wrOk = regWrEn && privileged;
    rdOk = regRdEn && privileged;
    strb = '0;
    strb.clrFault = excReturn;
    case (regSel)
      SEL_GLOBAL: begin
        strb.wrGlobal = wrOk;
        strb.rdGlobal = rdOk;
      end
      SEL_FAULT: begin
        // exception return has priority over a software write
        strb.wrFault = wrOk && !excReturn;
        strb.rdFault = rdOk;
      end
      SEL_THRESH: begin
        strb.wrThresh = wrOk;
        strb.rdThresh = rdOk;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/exc_mask_core.sv
module exc_mask_core
  import exc_mask_pkg::*;
#(
  parameter int PRIO_BITS = 3,
  parameter int NUM_BITS  = 9,
  localparam int SPW      = PRIO_BITS + 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  maskStrb_t             strb,
  input  logic [PRIO_BITS-1:0]  wrBits,
  input  logic                  pendValid,
  input  logic [NUM_BITS-1:0]   pendNum,
  input  logic [PRIO_BITS-1:0]  pendPrio,
  input  excClass_e             pendClass,
  input  logic signed [SPW-1:0] curPrio,
  output logic                  takeExc,
  output logic [NUM_BITS-1:0]   takeNum,
  output logic signed [SPW-1:0] boostPrio,
  output logic [PRIO_BITS-1:0]  rdBits
);

  localparam logic signed [SPW-1:0] PRI_ZERO = '0;
  localparam logic signed [SPW-1:0] PRI_HARD = {SPW{1'b1}};
  localparam logic signed [SPW-1:0] PRI_NMI  = {{(SPW-1){1'b1}}, 1'b0};

  logic                  globalQ;
  logic                  faultQ;
  logic [PRIO_BITS-1:0]  threshQ;
  logic signed [SPW-1:0] threshS;
  logic signed [SPW-1:0] boostS;
  logic signed [SPW-1:0] pendS;
  logic                  eligible;

  // mask registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalQ <= 1'b0;
      faultQ  <= 1'b0;
      threshQ <= '0;
    end else begin
      if (strb.wrGlobal) globalQ <= wrBits[0];
      if (strb.clrFault)     faultQ <= 1'b0;
      else if (strb.wrFault) faultQ <= wrBits[0];
      if (strb.wrThresh) threshQ <= wrBits;
    end
  end

  // boosted priority: each active mask sets a floor
  always_comb begin
    threshS = $signed({2'b00, threshQ});
    boostS  = curPrio;
    if (globalQ && boostS > PRI_ZERO) boostS = PRI_ZERO;
    if (faultQ && boostS > PRI_HARD)  boostS = PRI_HARD;
    if (threshQ != '0 && boostS > threshS) boostS = threshS;
  end

  // priority of the pending exception
  always_comb begin
    eligible = 1'b1;
    case (pendClass)
      CLS_CFG:  pendS = $signed({2'b00, pendPrio});
      CLS_HARD: pendS = PRI_HARD;
      CLS_NMI:  pendS = PRI_NMI;
      default: begin
        pendS    = PRI_ZERO;
        eligible = 1'b0;
      end
    endcase
  end

  assign takeExc   = pendValid && eligible && (pendS < boostS);
  assign takeNum   = takeExc ? pendNum : '0;
  assign boostPrio = boostS;

  assign rdBits = ({PRIO_BITS{strb.rdGlobal}} & PRIO_BITS'(globalQ))
                | ({PRIO_BITS{strb.rdFault}}  & PRIO_BITS'(faultQ))
                | ({PRIO_BITS{strb.rdThresh}} & threshQ);

  // boosting never makes the core less urgent
  assert_boost_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    boostPrio <= curPrio);

  assert_global_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (globalQ && pendValid && pendClass == CLS_CFG) |-> !takeExc);

  assert_fault_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (faultQ && pendValid && pendClass != CLS_NMI) |-> !takeExc);

  assert_ret_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrFault |=> !faultQ);

  assert_thresh_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (threshQ != '0 && pendValid && pendClass == CLS_CFG && pendPrio >= threshQ)
      |-> !takeExc);

  assert_nmi_open_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && pendClass == CLS_NMI && curPrio > PRI_NMI) |-> takeExc);

endmodule

// File: rtl/exc_mask_unit.sv
module exc_mask_unit
  import exc_mask_pkg::*;
#(
  parameter int PRIO_BITS = 3,
  parameter int NUM_BITS  = 9,
  parameter int DATA_W    = 32,
  localparam int SPW      = PRIO_BITS + 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pendValid,
  input  logic [NUM_BITS-1:0]   pendNum,
  input  logic [PRIO_BITS-1:0]  pendPrio,
  input  logic [1:0]            pendClass,
  input  logic signed [SPW-1:0] curPrio,
  input  logic                  privileged,
  input  logic                  regWrEn,
  input  logic                  regRdEn,
  input  logic [1:0]            regSel,
  input  logic [DATA_W-1:0]     regWrData,
  input  logic                  excReturn,
  output logic                  takeExc,
  output logic [NUM_BITS-1:0]   takeNum,
  output logic signed [SPW-1:0] boostPrio,
  output logic [DATA_W-1:0]     regRdData
);

  maskStrb_t            strb;
  logic [PRIO_BITS-1:0] rdBits;
  logic                 unusedWrHi;

  assign unusedWrHi = ^regWrData[DATA_W-1:PRIO_BITS];

  exc_mask_ctrl u_ctrl (
    .privileged (privileged),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regSel     (regSel_e'(regSel)),
    .excReturn  (excReturn),
    .strb       (strb)
  );

  exc_mask_core #(
    .PRIO_BITS (PRIO_BITS),
    .NUM_BITS  (NUM_BITS)
  ) u_core (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrBits    (regWrData[PRIO_BITS-1:0]),
    .pendValid (pendValid),
    .pendNum   (pendNum),
    .pendPrio  (pendPrio),
    .pendClass (excClass_e'(pendClass)),
    .curPrio   (curPrio),
    .takeExc   (takeExc),
    .takeNum   (takeNum),
    .boostPrio (boostPrio),
    .rdBits    (rdBits)
  );

  assign regRdData = DATA_W'(rdBits);

  assert_unpriv_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !privileged) |-> regRdData == '0);

endmodule

// File: tb/exc_mask_unit_tb.sv
module exc_mask_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PB  = 3;
  localparam int NB  = 9;
  localparam int DW  = 32;
  localparam int SPW = PB + 2;
  localparam int THREAD_LVL = 1 << PB;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                  rstN;
  logic                  pendValid;
  logic [NB-1:0]         pendNum;
  logic [PB-1:0]         pendPrio;
  logic [1:0]            pendClass;
  logic signed [SPW-1:0] curPrio;
  logic                  privileged;
  logic                  regWrEn;
  logic                  regRdEn;
  logic [1:0]            regSel;
  logic [DW-1:0]         regWrData;
  logic                  excReturn;
  logic                  takeExc;
  logic [NB-1:0]         takeNum;
  logic signed [SPW-1:0] boostPrio;
  logic [DW-1:0]         regRdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit mG, mF;
  int mT;

  exc_mask_unit #(.PRIO_BITS(PB), .NUM_BITS(NB), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .pendValid(pendValid), .pendNum(pendNum),
    .pendPrio(pendPrio), .pendClass(pendClass), .curPrio(curPrio),
    .privileged(privileged), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regSel(regSel), .regWrData(regWrData), .excReturn(excReturn),
    .takeExc(takeExc), .takeNum(takeNum), .boostPrio(boostPrio),
    .regRdData(regRdData)
  );

  function automatic int pendLevel();
    case (pendClass)
      2'b00:   return int'(pendPrio);
      2'b01:   return -1;
      2'b10:   return -2;
      default: return 99;
    endcase
  endfunction

  function automatic int expBoost();
    int b = int'(curPrio);
    if (mG && b > 0)  b = 0;
    if (mF && b > -1) b = -1;
    if (mT != 0 && b > mT) b = mT;
    return b;
  endfunction

  function automatic int expTake();
    return (pendValid && pendClass != 2'b11 && pendLevel() < expBoost()) ? 1 : 0;
  endfunction

  function automatic int expRead();
    if (!regRdEn || !privileged) return 0;
    case (regSel)
      2'd0:    return int'(mG);
      2'd1:    return int'(mF);
      2'd2:    return mT;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic checkNow(string tag);
    #1;
    chk(tag, "takeExc", int'(takeExc), expTake());
    chk(tag, "boostPrio", int'(boostPrio), expBoost());
    chk(tag, "takeNum", int'(takeNum), expTake() != 0 ? int'(pendNum) : 0);
    chk(tag, "regRdData", int'(regRdData), expRead());
  endtask

  // advance one clock, updating the model from inputs held over the edge
  task automatic tick();
    @(posedge clk);
    if (rstN) begin
      if (regWrEn && privileged && regSel == 2'd0) mG = regWrData[0];
      if (excReturn) mF = 1'b0;
      else if (regWrEn && privileged && regSel == 2'd1) mF = regWrData[0];
      if (regWrEn && privileged && regSel == 2'd2) mT = int'(regWrData[PB-1:0]);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    pendValid = 0; pendNum = '0; pendPrio = '0; pendClass = 2'b00;
    curPrio = SPW'(THREAD_LVL); privileged = 1; regWrEn = 0; regRdEn = 0;
    regSel = 2'd3; regWrData = '0; excReturn = 0;
  endtask

  task automatic writeReg(int sel, int val, string tag);
    idle(); regWrEn = 1; regSel = 2'(sel); regWrData = DW'(val);
    checkNow(tag); tick(); idle();
  endtask

  task automatic readReg(int sel, string tag);
    idle(); regRdEn = 1; regSel = 2'(sel);
    checkNow(tag); tick(); idle();
  endtask

  task automatic probe(int cls, int prio, int cur, string tag);
    idle(); pendValid = 1; pendClass = 2'(cls); pendPrio = PB'(prio);
    pendNum = NB'(16 + prio + cls * 3); curPrio = SPW'(cur);
    checkNow(tag); tick(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    mG = 0; mF = 0; mT = 0;
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    readReg(0, "R1"); readReg(1, "R1"); readReg(2, "R1");
    probe(0, 7, THREAD_LVL, "R1");
    // R2: equal priority not taken, more urgent taken
    probe(0, 3, 3, "R2"); probe(0, 2, 3, "R2");
    // R10: class and valid handling
    probe(3, 0, THREAD_LVL, "R10");
    idle(); pendClass = 2'b00; pendPrio = '0; curPrio = SPW'(THREAD_LVL);
    checkNow("R10"); tick();
    probe(2, 0, -1, "R10"); probe(2, 0, -2, "R10");
    // R4: global mask
    writeReg(0, 1, "R4");
    probe(0, 0, THREAD_LVL, "R4"); probe(1, 0, THREAD_LVL, "R4");
    probe(2, 0, THREAD_LVL, "R4");
    // R5: fault mask
    writeReg(1, 1, "R5");
    probe(1, 0, THREAD_LVL, "R5"); probe(2, 0, THREAD_LVL, "R5");
    // R6: exception return clears fault mask only; wins over write
    idle(); excReturn = 1; checkNow("R6"); tick(); idle();
    readReg(1, "R6"); readReg(0, "R6");
    probe(1, 0, THREAD_LVL, "R6");
    idle(); excReturn = 1; regWrEn = 1; regSel = 2'd1; regWrData = 32'd1;
    checkNow("R6"); tick(); idle();
    readReg(1, "R6");
    writeReg(0, 0, "R4");
    // R7: threshold
    writeReg(2, 3, "R7");
    probe(0, 3, THREAD_LVL, "R7"); probe(0, 2, THREAD_LVL, "R7");
    probe(0, 4, THREAD_LVL, "R7"); probe(0, 1, 2, "R7");
    // R8: unprivileged access
    idle(); privileged = 0; regWrEn = 1; regSel = 2'd2; regWrData = 32'd5;
    checkNow("R8"); tick(); idle();
    idle(); privileged = 0; regRdEn = 1; regSel = 2'd2;
    checkNow("R8"); tick(); idle();
    readReg(2, "R8");
    // R9: write takes effect next cycle; nested save and restore
    readReg(2, "R9");
    idle(); regWrEn = 1; regSel = 2'd2; regWrData = 32'd1;
    pendValid = 1; pendPrio = 3'd2; pendNum = 9'd40;
    checkNow("R9"); tick(); idle();
    probe(0, 2, THREAD_LVL, "R9"); probe(0, 0, THREAD_LVL, "R9");
    writeReg(2, 3, "R9");
    probe(0, 2, THREAD_LVL, "R9"); readReg(2, "R9");
    writeReg(2, 0, "R7");
    probe(0, 7, THREAD_LVL, "R7");
    // R11: unused select
    writeReg(3, 7, "R11"); readReg(3, "R11");
    readReg(0, "R11"); readReg(2, "R11");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      pendValid  = ($urandom_range(0, 9) < 8);
      pendClass  = 2'($urandom_range(0, 3));
      pendPrio   = PB'($urandom_range(0, THREAD_LVL - 1));
      pendNum    = NB'($urandom_range(1, 511));
      curPrio    = SPW'($urandom_range(0, THREAD_LVL + 3) - 3);
      privileged = ($urandom_range(0, 9) < 8);
      regWrEn    = ($urandom_range(0, 9) < 3);
      regRdEn    = ($urandom_range(0, 1) == 1);
      regSel     = 2'($urandom_range(0, 3));
      regWrData  = $urandom();
      excReturn  = ($urandom_range(0, 9) == 0);
      checkNow("R3");
      tick();
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule